// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block times one external memory bus cycle at a time for a processor-side bus master. When a request is accepted, the block holds a cycle-active strobe for a programmed minimum number of wait states. It can then stretch the cycle further for as long as an external active-low transfer-acknowledge input stays deasserted. When the cycle ends, it issues a one-clock done pulse.

The cycle length is the larger of two values: the programmed minimum, and the point at which acknowledge is recognised. A run-time mode bit selects how the acknowledge pin is used. In one mode it is taken directly, as a signal synchronous to the bus clock. In the other it first passes through a synchronizer chain.

Cycles programmed with zero wait states, and cycles tagged as DRAM-type, never look at acknowledge. Their length comes from the programmed count alone.

Top module: `bus_wait_ctrl`

## Requirements
- R1: After reset, and until the first request is accepted, `cyc_active` and `cyc_done` are both low.
- R2: A request is accepted in a clock where the block is idle and both `req_valid` and `is_master` are high. `cyc_active` rises in the next clock. No request is accepted while `is_master` is low.
- R3: The wait count `wait_min` is captured at acceptance. When acknowledge is already asserted, the cycle keeps `cyc_active` high for exactly `wait_min`+1 clocks.
- R4: With `wait_min` ≥ 1 and a normal cycle, the cycle is extended for as long as acknowledge stays deasserted. This holds for any number of clocks beyond the minimum. Acknowledge is asserted when `xfer_ack_n` is 0.
- R5: Once the minimum has expired, `cyc_done` is high in the clock right after the clock in which acknowledge is recognised.
- R6: A cycle accepted with `wait_min` = 0 completes after one active clock, whatever the value of `xfer_ack_n`.
- R7: A cycle accepted with `req_dram` = 1 ignores acknowledge. It lasts `wait_min`+1 active clocks.
- R8: With `ack_async` = 1, acknowledge is recognised two clocks later than with `ack_async` = 0.
- R9: Acknowledge asserted while the minimum count is still running is remembered. The cycle then ends as soon as the minimum expires, and never earlier.
- R10: Acknowledge is ignored while `is_master` is low. An active cycle then stays open until the block is master again and acknowledge is recognised.
- R11: `cyc_done` lasts exactly one clock, during which `cyc_active` is low. The earliest next acceptance is the clock after `cyc_done`, which makes `cyc_active` high two clocks after `cyc_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request for an external bus cycle |
| req_dram | input | 1 | Cycle is DRAM-type (acknowledge unused) |
| wait_min | input | WAIT_W | Programmed minimum wait states |
| ack_async | input | 1 | 1: acknowledge passed through synchronizer; 0: used directly |
| is_master | input | 1 | This port currently owns the external bus |
| xfer_ack_n | input | 1 | Transfer acknowledge, active low |
| cyc_active | output | 1 | High while a bus cycle is in progress |
| cyc_done | output | 1 | One-clock pulse when a cycle completes |

## Verification
The bench builds the block with its defaults: WAIT_W = 4, so minimum counts from 0 to 15 are reachable, and a two-stage synchronizer, so the asynchronous path has a fixed two-clock lag. These values let directed cycles cover several cases. One case is the zero-wait boundary. Another is a minimum of 15 with acknowledge held off well past it. Others are early acknowledge during the count, loss of mastership mid-cycle, and back-to-back requests, each run in both acknowledge modes. A behavioural model predicts both outputs every clock.

// File: rtl/bwc_pkg.sv
package bwc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } bwc_state_e;

    typedef struct packed {
        bwc_state_e state;
        logic       ign_ack;
        logic       ack_seen;
    } bwc_ctrl_t;

endpackage

// File: rtl/bwc_ack_sync.sv
module bwc_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_n_i,
    input  logic async_mode_i,
    output logic ack_o
);
    logic [STAGES-1:0] stg_d, stg_q;

    always_comb begin
        stg_d = {stg_q[STAGES-2:0], ~ack_n_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign ack_o = async_mode_i ? stg_q[STAGES-1] : ~ack_n_i;

    generate
        if (STAGES == 2) begin : g_chk2
            // R8: asynchronous path lags the pin by two clocks
            p_async_lag_r8: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) && $past(rst_n, 2) |-> stg_q[1] == !$past(ack_n_i, 2));
        end
    endgenerate

endmodule

// File: rtl/bwc_wait_timer.sv
module bwc_wait_timer #(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WAIT_W-1:0] load_val_i,
    input  logic              run_i,
    output logic              expired_o
);
    logic [WAIT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)                   cnt_d = load_val_i;
        else if (run_i && cnt_q != 0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);

    // R3: a running count moves down by exactly one per clock
    p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run_i && !load_i && cnt_q != 0 |=> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/bus_wait_ctrl.sv
module bus_wait_ctrl
    import bwc_pkg::*;
#(
    parameter int WAIT_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_dram,
    input  logic [WAIT_W-1:0] wait_min,
    input  logic              ack_async,
    input  logic              is_master,
    input  logic              xfer_ack_n,
    output logic              cyc_active,
    output logic              cyc_done
);
    bwc_ctrl_t ctl_d, ctl_q;
    logic      ack_eff;
    logic      ack_live;
    logic      accept;
    logic      min_expired;

    bwc_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk          (clk),
        .rst_n        (rst_n),
        .ack_n_i      (xfer_ack_n),
        .async_mode_i (ack_async),
        .ack_o        (ack_eff)
    );

    bwc_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (accept),
        .load_val_i (wait_min),
        .run_i      (ctl_q.state == ST_RUN),
        .expired_o  (min_expired)
    );

    assign accept   = (ctl_q.state == ST_IDLE) && req_valid && is_master;
    assign ack_live = ack_eff && is_master && (ctl_q.state == ST_RUN) && !ctl_q.ign_ack;

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (accept) begin
                    ctl_d.state    = ST_RUN;
                    ctl_d.ign_ack  = req_dram || (wait_min == '0);
                    ctl_d.ack_seen = 1'b0;
                end
            end
            ST_RUN: begin
                if (ack_live) ctl_d.ack_seen = 1'b1;
                if (min_expired && (ctl_q.ign_ack || ctl_q.ack_seen || ack_live))
                    ctl_d.state = ST_DONE;
            end
            ST_DONE: begin
                ctl_d.state = ST_IDLE;
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.state    <= ST_IDLE;
            ctl_q.ign_ack  <= 1'b0;
            ctl_q.ack_seen <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cyc_active = (ctl_q.state == ST_RUN);
    assign cyc_done   = (ctl_q.state == ST_DONE);

    // R11: done is a single-clock pulse and is followed by an idle clock
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |=> !cyc_done && !cyc_active);
    // R11: done never overlaps an active cycle
    p_done_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(cyc_done && cyc_active));
    // R2: a cycle only starts from an accepted request while master
    p_start_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cyc_active) |-> $past(req_valid) && $past(is_master));
    // R10: without mastership an acknowledge-dependent cycle cannot finish
    p_no_master_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_active && !ctl_q.ign_ack && !ctl_q.ack_seen && !is_master |=> !cyc_done);
    // R6 / R7: acknowledge-free cycles finish as soon as the count runs out
    p_ign_finish_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_active && ctl_q.ign_ack && min_expired |=> cyc_done);

endmodule

// File: tb/bus_wait_ctrl_test.sv
module bus_wait_ctrl_test;
    localparam int WAIT_W = 4;

    logic clk = 1'b0;
    logic rst_n;
    logic req_valid, req_dram, ack_async, is_master, xfer_ack_n;
    logic [WAIT_W-1:0] wait_min;
    logic cyc_active, cyc_done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // reference model state
    int m_state;   // 0 idle, 1 run, 2 done
    int m_cnt;
    bit m_ign, m_seen, m_p1, m_p2;

    always #10 clk = ~clk;

    bus_wait_ctrl #(.WAIT_W(WAIT_W), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dram(req_dram),
        .wait_min(wait_min), .ack_async(ack_async), .is_master(is_master),
        .xfer_ack_n(xfer_ack_n), .cyc_active(cyc_active), .cyc_done(cyc_done)
    );

    task automatic model_reset();
        m_state = 0; m_cnt = 0; m_ign = 0; m_seen = 0; m_p1 = 0; m_p2 = 0;
    endtask

    task automatic model_next();
        bit raw, eff, live;
        int ns;
        raw  = !xfer_ack_n;
        eff  = ack_async ? m_p2 : raw;
        live = eff && is_master && (m_state == 1) && !m_ign;
        ns   = m_state;
        if (m_state == 0) begin
            if (req_valid && is_master) begin
                ns = 1; m_cnt = int'(wait_min);
                m_ign = req_dram || (wait_min == 0); m_seen = 0;
            end
        end else if (m_state == 1) begin
            if (m_cnt == 0 && (m_ign || m_seen || live)) ns = 2;
            if (live) m_seen = 1;
            if (m_cnt > 0) m_cnt--;
        end else begin
            ns = 0;
        end
        m_state = ns;
        m_p2 = m_p1;
        m_p1 = raw;
    endtask

    task automatic compare(string tag);
        bit ea, ed;
        ea = (m_state == 1);
        ed = (m_state == 2);
        n_checks++;
        if (cyc_active !== ea || cyc_done !== ed) begin
            n_fail++;
            $display("FAIL %s t=%0t active=%b done=%b expected active=%b done=%b",
                     tag, $time, cyc_active, cyc_done, ea, ed);
        end
    endtask

    // inputs are already set; advance one clock and compare at the falling edge
    task automatic step(string tag);
        model_next();
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle_inputs();
        req_valid = 0; req_dram = 0; wait_min = '0; ack_async = 0;
        is_master = 1; xfer_ack_n = 1;
    endtask

    // issue one request for one clock, then let the cycle run
    task automatic issue(string tag, bit dram, int w, bit am);
        req_valid = 1; req_dram = dram; wait_min = WAIT_W'(w); ack_async = am;
        step(tag);
        req_valid = 0;
    endtask

    task automatic run(string tag, int n);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    initial begin
        #4_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        if (!finished) begin
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst_n = 0;
        model_reset();
        repeat (3) @(negedge clk);
        compare("R1 reset");
        rst_n = 1;
        run("R1 idle after reset", 3);

        // R3: ack already asserted, minimum sets length
        xfer_ack_n = 0;
        issue("R3 accept", 0, 3, 0);
        run("R3 minimum length", 6);
        xfer_ack_n = 1;

        // R2: no acceptance without mastership
        is_master = 0;
        req_valid = 1; wait_min = 2;
        run("R2 not master", 4);
        req_valid = 0; is_master = 1;
        run("R2 idle", 2);

        // R4 / R5: extension, completion one clock after ack
        issue("R4 accept", 0, 2, 0);
        run("R4 extended", 12);
        xfer_ack_n = 0;
        step("R5 ack recognised");
        xfer_ack_n = 1;
        run("R5 completion", 3);

        // R6: zero wait ignores ack
        issue("R6 zero wait", 0, 0, 0);
        run("R6 completion", 3);

        // R7: DRAM-type ignores ack
        issue("R7 dram", 1, 4, 0);
        run("R7 completion", 7);
        xfer_ack_n = 0;
        issue("R7 dram ack on", 1, 2, 1);
        run("R7 completion ack on", 5);
        xfer_ack_n = 1;

        // R8: async latency
        issue("R8 async accept", 0, 1, 1);
        run("R8 extended", 5);
        xfer_ack_n = 0;
        run("R8 async lag", 5);
        xfer_ack_n = 1;
        run("R8 settle", 3);

        // R9: early ack pulse held
        issue("R9 accept", 0, 6, 0);
        xfer_ack_n = 0;
        step("R9 early ack");
        xfer_ack_n = 1;
        run("R9 minimum honoured", 9);
        issue("R9 async accept", 0, 15, 1);
        xfer_ack_n = 0;
        run("R9 early async", 2);
        xfer_ack_n = 1;
        run("R9 long minimum", 20);

        // R10: mastership lost mid-cycle
        issue("R10 accept", 0, 1, 0);
        is_master = 0; xfer_ack_n = 0;
        run("R10 not master", 6);
        is_master = 1;
        run("R10 master back", 3);
        xfer_ack_n = 1;
        // R10: ack toggling while idle has no effect
        for (int i = 0; i < 6; i++) begin
            xfer_ack_n = i[0];
            step("R10 idle ack");
        end
        xfer_ack_n = 1;

        // R11: back-to-back requests held valid
        xfer_ack_n = 0;
        req_valid = 1; wait_min = 1; ack_async = 0; req_dram = 0;
        run("R11 back to back", 12);
        ack_async = 1;
        run("R11 back to back async", 12);
        req_valid = 0; xfer_ack_n = 1;
        run("R11 drain", 4);

        // mixed sweep over counts and modes
        for (int w = 0; w < 16; w += 3) begin
            for (int am = 0; am < 2; am++) begin
                issue("R4 sweep", 0, w, am[0]);
                run("R4 sweep wait", w + 3);
                xfer_ack_n = 0;
                run("R5 sweep ack", 5);
                xfer_ack_n = 1;
            end
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule